// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes a received frame, presented one byte per cycle with start and end markers, and stores it into a ring of receive descriptors kept in a word-wide memory. Before each frame it reads the current descriptor: a link offset, the buffer capacity in bytes and a status word. It then packs the payload bytes into the descriptor's data area, four to a word. When the frame ends it writes the status word once, with the byte count and the completion flags.

The address of the next descriptor is the base-address input plus the link offset held in the current descriptor. The last link may point back to the first descriptor, which closes the ring. A descriptor whose completion flags are still set belongs to software. The block waits on such a descriptor and raises `stall`, and it polls the status word until software clears both flags. The `rdy` output shows that a free descriptor is loaded and a frame may start.

Memory reads have one cycle of latency. Addresses are word addresses. Each write covers a full 32-bit word.

Top module: `rdw_ring_writer`

## Requirements
- R1: After reset, the block writes nothing, holds `frame_done`, `rdy` and `stall` low, and its first descriptor read is at `base_addr` itself.
- R2: A descriptor is laid out as follows. Word +0 holds the 32-bit link offset. Word +1 holds the capacity in bits [15:0]. Word +2 is the status word. The data area starts at word +3, and payload byte i goes to word +3+i/4, bits [8*(i%4)+7 : 8*(i%4)].
- R3: Payload words are written in the order they fill. A partly filled final word is written with its unused upper bytes set to zero.
- R4: The count in status bits [15:0] equals the number of bytes stored, and it never exceeds the capacity.
- R5: Bytes beyond the capacity are discarded and nothing is written past the data area. Status bit 29 (no room) is 1 exactly when bytes were discarded.
- R6: After the last data write, the status word is written once, with bit 31 (end-of-frame placed) and bit 30 (count final) both set. `frame_done` pulses in that same cycle.
- R7: The next descriptor is read at `base_addr` + link, taken modulo the memory size, so a link back to offset 0 wraps the ring.
- R8: A fetched descriptor whose status bit 31 or bit 30 is set raises `stall`, keeps `rdy` low and causes no writes. The block keeps polling until both bits read as zero and then arms.
- R9: Bytes are ignored while the block is not armed, and so are bytes without a start marker while it is armed. Neither case causes a write.
- R10: `rdy` is high only while a free descriptor is loaded and no frame is in progress. It falls right after the byte that carries the end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Ring base word address |
| in_valid | input | 1 | Byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_byte | input | 8 | Payload byte |
| rd_en | output | 1 | Memory read enable |
| rd_addr | output | AW | Memory read address |
| rd_data | input | 32 | Memory read data, one cycle after rd_en |
| wr_en | output | 1 | Memory write enable |
| wr_addr | output | AW | Memory write address |
| wr_data | output | 32 | Memory write data |
| frame_done | output | 1 | Status write of a finished frame |
| rdy | output | 1 | Free descriptor loaded, frame may start |
| stall | output | 1 | Current descriptor still owned by software |

## Verification
A wrong byte lane or a wrong word index shows up on the first data write of a frame, as a mismatched address or data word. A count that runs past the capacity, or a no-room flag that does not clear, shows up in the status write at the end of the same frame. A wrong link sum sends the next frame's writes to the wrong addresses. A stale ownership check shows up either as `stall` failing to rise when the ring wraps onto a used descriptor, or as writes to a descriptor that software has not released.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  localparam int LINK_OFS = 0;
  localparam int SIZE_OFS = 1;
  localparam int STAT_OFS = 2;
  localparam int DATA_OFS = 3;
  localparam int ST_DONE_BIT  = 31;
  localparam int ST_FINAL_BIT = 30;
  localparam int ST_ROOM_BIT  = 29;

  typedef enum logic [2:0] {
    ST_REQ, ST_WAIT, ST_TAKE, ST_ARMED, ST_RECV, ST_WB
  } rdw_state_e;
endpackage

// File: rtl/rdw_packer.sv
module rdw_packer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          take,
  input  logic          last,
  input  logic [7:0]    byte_in,
  input  logic [CW-1:0] size,
  output logic          word_wr,
  output logic [CW-3:0] word_idx,
  output logic [31:0]   word_data,
  output logic [CW-1:0] count,
  output logic          ovf
);
  logic [CW-1:0] cnt;
  logic [31:0]   pack;
  logic [31:0]   merged;
  logic [1:0]    lane;
  logic          accept;
  logic          ovf_q;

  assign lane   = cnt[1:0];
  assign accept = take && (cnt < size);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign merged[8*g +: 8] = (lane == 2'(g)) ? byte_in : pack[8*g +: 8];
  end

  assign word_wr   = accept && (lane == 2'd3 || last ||
                     (({1'b0, cnt} + 1'b1) == {1'b0, size}));
  assign word_idx  = cnt[CW-1:2];
  assign word_data = merged;
  assign count     = cnt;
  assign ovf       = ovf_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt   <= '0;
      pack  <= '0;
      ovf_q <= 1'b0;
    end else if (take) begin
      if (accept) begin
        cnt  <= cnt + 1'b1;
        pack <= word_wr ? 32'd0 : merged;
      end else begin
        ovf_q <= 1'b1;
      end
    end
  end

  assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (rst)
    cnt <= size);
  assert_ovf_full_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt == size));
endmodule

// File: rtl/rdw_addr_gen.sv
module rdw_addr_gen
  import rdw_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 14
) (
  input  logic [31:0]   base,
  input  logic [31:0]   link,
  input  logic [AW-1:0] cur,
  input  logic [IW-1:0] widx,
  output logic [AW-1:0] next_desc,
  output logic [AW-1:0] data_addr,
  output logic [AW-1:0] stat_addr
);
  logic [31:0] sum;
  assign sum       = base + link;
  assign next_desc = sum[AW-1:0];
  assign data_addr = cur + AW'(DATA_OFS) + AW'(widx);
  assign stat_addr = cur + AW'(STAT_OFS);
endmodule

// File: rtl/rdw_ring_writer.sv
module rdw_ring_writer
  import rdw_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   base_addr,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_byte,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          frame_done,
  output logic          rdy,
  output logic          stall
);
  localparam int IW = CW - 2;

  rdw_state_e    state;
  logic [1:0]    idx;
  logic [AW-1:0] cur;
  logic [31:0]   link;
  logic [CW-1:0] size;
  logic          take;
  logic          pk_wr;
  logic [IW-1:0] pk_idx;
  logic [31:0]   pk_word;
  logic [CW-1:0] pk_cnt;
  logic          pk_ovf;
  logic [AW-1:0] next_desc;
  logic [AW-1:0] data_addr;
  logic [AW-1:0] stat_addr;
  logic [31:0]   status;
  logic [AW-1:0] wr_off;

  assign take = in_valid && ((state == ST_ARMED && in_sof) || state == ST_RECV);
  assign rdy  = (state == ST_ARMED);

  always_comb begin
    status = '0;
    status[CW-1:0]      = pk_cnt;
    status[ST_DONE_BIT]  = 1'b1;
    status[ST_FINAL_BIT] = 1'b1;
    status[ST_ROOM_BIT]  = pk_ovf;
  end

  rdw_packer #(.CW(CW)) u_pack (
    .clk(clk), .rst(rst), .clear(state == ST_WB), .take(take),
    .last(in_eof), .byte_in(in_byte), .size(size),
    .word_wr(pk_wr), .word_idx(pk_idx), .word_data(pk_word),
    .count(pk_cnt), .ovf(pk_ovf)
  );

  rdw_addr_gen #(.AW(AW), .IW(IW)) u_addr (
    .base(base_addr), .link(link), .cur(cur), .widx(pk_idx),
    .next_desc(next_desc), .data_addr(data_addr), .stat_addr(stat_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_REQ;
      idx        <= 2'd0;
      cur        <= base_addr[AW-1:0];
      link       <= '0;
      size       <= '0;
      rd_en      <= 1'b0;
      rd_addr    <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      frame_done <= 1'b0;
      stall      <= 1'b0;
    end else begin
      rd_en      <= 1'b0;
      wr_en      <= 1'b0;
      frame_done <= 1'b0;
      case (state)
        ST_REQ: begin
          rd_en   <= 1'b1;
          rd_addr <= cur + AW'(idx);
          state   <= ST_WAIT;
        end
        ST_WAIT: state <= ST_TAKE;
        ST_TAKE: begin
          if (idx == 2'(LINK_OFS)) begin
            link  <= rd_data;
            idx   <= 2'(SIZE_OFS);
            state <= ST_REQ;
          end else if (idx == 2'(SIZE_OFS)) begin
            size  <= rd_data[CW-1:0];
            idx   <= 2'(STAT_OFS);
            state <= ST_REQ;
          end else if (rd_data[ST_DONE_BIT] || rd_data[ST_FINAL_BIT]) begin
            stall <= 1'b1;
            state <= ST_REQ;
          end else begin
            stall <= 1'b0;
            state <= ST_ARMED;
          end
        end
        ST_ARMED: if (in_valid && in_sof) state <= in_eof ? ST_WB : ST_RECV;
        ST_RECV:  if (in_valid && in_eof) state <= ST_WB;
        ST_WB: begin
          wr_en      <= 1'b1;
          wr_addr    <= stat_addr;
          wr_data    <= status;
          frame_done <= 1'b1;
          cur        <= next_desc;
          idx        <= 2'(LINK_OFS);
          state      <= ST_REQ;
        end
        default: state <= ST_REQ;
      endcase
      if (pk_wr) begin
        wr_en   <= 1'b1;
        wr_addr <= data_addr;
        wr_data <= pk_word;
      end
    end
  end

  assign wr_off = wr_addr - cur;

  assert_done_stat_R6: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (wr_en && wr_addr == $past(cur) + AW'(STAT_OFS)));
  assert_data_area_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !frame_done) |-> (int'(wr_off) >= DATA_OFS &&
      int'(wr_off) < DATA_OFS + (int'(size) + 3) / 4));
  assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!rdy && !wr_en));
  assert_armed_noread_R10: assert property (@(posedge clk) disable iff (rst)
    rdy |-> !rd_en);
endmodule

// File: tb/sim_rdw_ring_writer.sv
module sim_rdw_ring_writer;
  localparam int CLK_NS = 10;
  localparam int AW = 8;
  localparam logic [31:0] BASE = 32'h40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_byte = '0;
  logic rd_en, wr_en, frame_done, rdy, stall;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic clr_en = 1'b0;
  logic [AW-1:0] clr_addr = '0;
  logic [31:0] mem [256];

  int total = 0, bad = 0, done_cnt = 0;
  bit seen_rd = 1'b0;
  logic [AW-1:0] first_rd = '0;
  logic [40:0] expq[$];

  always #(CLK_NS/2) clk = ~clk;

  rdw_ring_writer #(.AW(AW), .CW(16)) u0 (
    .clk(clk), .rst(rst), .base_addr(BASE), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_byte(in_byte),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_done(frame_done), .rdy(rdy), .stall(stall)
  );

  // memory model: one-cycle read latency, ring of three descriptors
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'd0;
      mem[8'h40] <= 32'h10; mem[8'h41] <= 32'd10;
      mem[8'h50] <= 32'h20; mem[8'h51] <= 32'd6;
      mem[8'h60] <= 32'h00; mem[8'h61] <= 32'd16;
      rd_data <= 32'd0;
    end else begin
      if (rd_en) rd_data <= mem[rd_addr];
      if (wr_en) mem[wr_addr] <= wr_data;
      if (clr_en) mem[clr_addr] <= 32'd0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (rd_en && !seen_rd) begin seen_rd = 1'b1; first_rd = rd_addr; end
      if (frame_done) done_cnt++;
      if (wr_en) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R9 unexpected write", {24'd0, wr_addr}, 32'd0);
        end else begin
          logic [40:0] e;
          e = expq.pop_front();
          chk(wr_addr == e[39:32], "R2 write address", {24'd0, wr_addr}, {24'd0, e[39:32]});
          chk(frame_done == e[40], "R6 frame_done with status", {31'd0, frame_done}, {31'd0, e[40]});
          if (e[40]) begin
            chk(wr_data[15:0] == e[15:0], "R4 count", {16'd0, wr_data[15:0]}, {16'd0, e[15:0]});
            chk(wr_data[29] == e[29], "R5 no-room bit", {31'd0, wr_data[29]}, {31'd0, e[29]});
            chk(wr_data[31:30] == 2'b11, "R6 completion flags", {30'd0, wr_data[31:30]}, 32'd3);
          end else begin
            chk(wr_data == e[31:0], "R3 data word", wr_data, e[31:0]);
          end
        end
      end else if (frame_done) begin
        chk(1'b0, "R6 frame_done without write", 32'd1, 32'd0);
      end
    end
  end

  function automatic logic [7:0] pat(input int key, input int i);
    return 8'(key * 37 + i * 5 + 1);
  endfunction

  task automatic wait_rdy(input string req);
    int n = 0;
    while (!rdy && n < 300) begin @(negedge clk); n++; end
    chk(rdy, req, {31'd0, rdy}, 32'd1);
  endtask

  task automatic send_frame(input int key, input int n, input int dptr, input int size);
    int cnt = 0;
    bit ovf = 1'b0;
    logic [31:0] pack = '0;
    for (int i = 0; i < n; i++) begin
      if (cnt < size) begin
        pack[8*(cnt%4) +: 8] = pat(key, i);
        cnt++;
        if (cnt % 4 == 0 || i == n - 1 || cnt == size) begin
          expq.push_back({1'b0, 8'(dptr + 3 + (cnt - 1) / 4), pack});
          pack = '0;
        end
      end else ovf = 1'b1;
    end
    expq.push_back({1'b1, 8'(dptr + 2), 2'b11, ovf, 13'd0, 16'(cnt)});
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == n - 1); in_byte = pat(key, i);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk(!rdy, "R10 rdy drops after end marker", {31'd0, rdy}, 32'd0);
  endtask

  task automatic stray(input bit with_sof);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_sof = with_sof && (i == 0); in_eof = (i == 2);
      in_byte = 8'hEE;
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en && !frame_done, "R1 no write in reset", {30'd0, wr_en, frame_done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rdy && !stall && !wr_en, "R1 idle after reset", {29'd0, rdy, stall, wr_en}, 32'd0);
    wait_rdy("R10 armed on free descriptor");
    chk(first_rd == BASE[AW-1:0], "R1 first fetch at base", {24'd0, first_rd}, BASE);
    send_frame(1, 7, 'h40, 10);            // fits, partial last word
    wait_rdy("R7 next descriptor via link");
    stray(1'b0);                           // no start marker while armed
    repeat (4) @(negedge clk);
    chk(rdy, "R9 armed after stray bytes", {31'd0, rdy}, 32'd1);
    send_frame(2, 9, 'h50, 6);             // overflow, count saturates
    stray(1'b1);                           // frame while fetching
    wait_rdy("R7 third descriptor");
    send_frame(3, 16, 'h60, 16);           // exactly full
    repeat (40) @(negedge clk);
    chk(stall && !rdy, "R8 stall on owned descriptor after wrap", {30'd0, stall, rdy}, 32'd2);
    clr_addr = 8'h42; clr_en = 1'b1;
    @(negedge clk);
    clr_en = 1'b0;
    wait_rdy("R8 resumes after release");
    chk(!stall, "R8 stall cleared", {31'd0, stall}, 32'd0);
    send_frame(4, 1, 'h40, 10);            // single byte frame
    repeat (40) @(negedge clk);
    chk(stall, "R8 second owned descriptor", {31'd0, stall}, 32'd1);
    chk(expq.size() == 0, "R6 all expected writes seen", expq.size(), 32'd0);
    chk(done_cnt == 4, "R6 frame_done count", done_cnt, 32'd4);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule